// File: doc/BRIEF.md
# Double to Single Store Converter

This block turns a 64-bit double-precision register image into the 32-bit single-precision word that a floating-point single store writes to memory. It takes one operand per cycle, qualified by a valid strobe, and presents the converted word one clock later with its own valid strobe. It does no rounding and raises no flags: every conversion is a truncation.

Each operand falls into one of three regions, set by its biased exponent. In the direct region (exponent above 896, or a signed zero) the result is a plain selection of input bits. This also covers normal values, infinities and NaNs. In the denormal region (exponent 874 to 896) the significand, with its hidden one restored, is shifted right so that the exponent reaches the single-precision minimum of -126. The result is then packed with a zero exponent field. In the flush region (every other exponent) the result is all zeros. The three regions are named `REG_DIRECT`, `REG_DENORM` and `REG_FLUSH`. The output register moves from its hold condition to a load whenever the input strobe is high.

Top module: `d2s_store_conv`

## Requirements
- R1: While reset is asserted and after its release, before any valid input, `out_valid` is 0 and `out_word` is 0.
- R2: A cycle with `in_valid` high produces `out_valid` high exactly one clock later, and `out_word` then holds the conversion of that cycle's `in_dword`. A cycle with `in_valid` low produces `out_valid` low one clock later.
- R3: Input layout, bit 63 the MSB: sign at bit 63, biased exponent at bits 62:52, fraction at bits 51:0. When the exponent exceeds 896, `out_word` equals `{in_dword[63:62], in_dword[58:29]}`.
- R4: When bits 62:0 are all zero (a signed zero), `out_word` is `{in_dword[63], 31'b0}`, so both +0 and -0 keep their sign.
- R5: When the exponent is from 874 to 896 inclusive, `out_word` is `{sign, 8'b0, m}`. Here m is bits 51:29 of the 53-bit value `{1'b1, fraction}` shifted right by (897 - exponent), a count from 1 to 23.
- R6: When the exponent is below 874 and the input is not a signed zero, `out_word` is all zeros, with the sign cleared as well.
- R7: An infinity or NaN (exponent 2047) goes through the direct path. The output exponent field, bits 30:23, is all ones, and the output fraction is `in_dword[51:29]`.
- R8: While `in_valid` is low, `out_word` keeps its previous value whatever `in_dword` carries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Marks `in_dword` as an operand to convert |
| in_dword | input | 64 | Double-precision register image |
| out_valid | output | 1 | Marks `out_word` as a new result |
| out_word | output | 32 | Single-precision store word |

## Verification
Each result is due on the first rising edge after the cycle in which its operand is presented. There is one register between input and output, so `out_valid` and `out_word` change on that edge. The bench drives each operand on a falling edge and drops the strobe on the next falling edge. It samples both outputs at that second falling edge, half a period after they settle. A further idle falling edge, with a changed `in_dword`, checks that the strobe has gone low and the word has held.

// File: rtl/d2s_pkg.sv
package d2s_pkg;

    localparam int DBL_W      = 64;
    localparam int SGL_W      = 32;
    localparam int EXP_W      = 11;
    localparam int FRAC_W     = 52;
    localparam int SEXP_W     = 8;
    localparam int MANT_W     = SGL_W - 1 - SEXP_W;
    localparam int DBL_BIAS   = 1023;
    localparam int SGL_EMIN   = -126;
    localparam int MAX_SHIFT  = 23;
    localparam int SHIFT_W    = $clog2(MAX_SHIFT + 1);

    // Biased-exponent region edges
    localparam int DIRECT_ABOVE = DBL_BIAS + SGL_EMIN - 1;        // 896
    localparam int DENORM_FROM  = DIRECT_ABOVE - MAX_SHIFT + 1;   // 874
    localparam int SHIFT_REF    = DIRECT_ABOVE + 1;               // 897

    typedef enum logic [1:0] {
        REG_DIRECT = 2'd0,
        REG_DENORM = 2'd1,
        REG_FLUSH  = 2'd2
    } region_e;

endpackage

// File: rtl/d2s_classify.sv
module d2s_classify
    import d2s_pkg::*;
(
    input  logic [EXP_W-1:0]   exp_i,
    input  logic               mag_zero_i,
    output region_e            region_o,
    output logic [SHIFT_W-1:0] shift_o
);

    logic [EXP_W:0] diff;

    always_comb begin
        diff    = (EXP_W+1)'(SHIFT_REF) - {1'b0, exp_i};
        shift_o = diff[SHIFT_W-1:0];
        if (mag_zero_i || (int'(exp_i) > DIRECT_ABOVE)) begin
            region_o = REG_DIRECT;
        end else if (int'(exp_i) >= DENORM_FROM) begin
            region_o = REG_DENORM;
        end else begin
            region_o = REG_FLUSH;
        end
    end

endmodule

// File: rtl/d2s_denorm.sv
module d2s_denorm
    import d2s_pkg::*;
(
    input  logic [FRAC_W-1:0]  frac_i,
    input  logic [SHIFT_W-1:0] shift_i,
    output logic [MANT_W-1:0]  mant_o
);

    logic [FRAC_W:0] sig;
    logic [FRAC_W:0] shifted;

    always_comb begin
        sig     = {1'b1, frac_i};
        shifted = sig >> shift_i;
        mant_o  = shifted[FRAC_W-1 -: MANT_W];
    end

endmodule

// File: rtl/d2s_pack.sv
module d2s_pack
    import d2s_pkg::*;
(
    input  region_e           region_i,
    input  logic [DBL_W-1:0]  dword_i,
    input  logic [MANT_W-1:0] mant_i,
    output logic [SGL_W-1:0]  word_o
);

    always_comb begin
        unique case (region_i)
            REG_DIRECT: word_o = {dword_i[DBL_W-1 -: 2],
                                  dword_i[DBL_W-6 -: SGL_W-2]};
            REG_DENORM: word_o = {dword_i[DBL_W-1], {SEXP_W{1'b0}}, mant_i};
            REG_FLUSH:  word_o = '0;
            default:    word_o = '0;
        endcase
    end

endmodule

// File: rtl/d2s_store_conv.sv
module d2s_store_conv
    import d2s_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [63:0]      in_dword,
    output logic             out_valid,
    output logic [31:0]      out_word
);

    logic [EXP_W-1:0]   exp_f;
    logic               mag_zero;
    region_e            region;
    logic [SHIFT_W-1:0] shift_amt;
    logic [MANT_W-1:0]  mant;
    logic [SGL_W-1:0]   word_next;

    assign exp_f    = in_dword[DBL_W-2 -: EXP_W];
    assign mag_zero = (in_dword[DBL_W-2:0] == '0);

    d2s_classify u_classify (
        .exp_i      (exp_f),
        .mag_zero_i (mag_zero),
        .region_o   (region),
        .shift_o    (shift_amt)
    );

    d2s_denorm u_denorm (
        .frac_i  (in_dword[FRAC_W-1:0]),
        .shift_i (shift_amt),
        .mant_o  (mant)
    );

    d2s_pack u_pack (
        .region_i (region),
        .dword_i  (in_dword),
        .mant_i   (mant),
        .word_o   (word_next)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_word  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_word <= word_next;
            end
        end
    end

    // Assertions
    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_idle_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_word));

    assert_denorm_exp_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && int'(in_dword[62:52]) >= DENORM_FROM
                  && int'(in_dword[62:52]) <= DIRECT_ABOVE)
        |=> (out_word[30:23] == 8'h00) && (out_word[31] == $past(in_dword[63])));

    assert_flush_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && int'(in_dword[62:52]) < DENORM_FROM && in_dword[62:0] != '0)
        |=> (out_word == '0));

    assert_direct_sign_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && int'(in_dword[62:52]) > DIRECT_ABOVE)
        |=> (out_word[31] == $past(in_dword[63])));

    assert_special_exp_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_dword[62:52] == 11'h7FF) |=> (out_word[30:23] == 8'hFF));

endmodule

// File: tb/d2s_store_conv_tb.sv
module d2s_store_conv_tb;

    logic        clk;
    logic        rst_n;
    logic        in_valid;
    logic [63:0] in_dword;
    logic        out_valid;
    logic [31:0] out_word;

    int checks;
    int errors;
    bit done;

    d2s_store_conv u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_dword  (in_dword),
        .out_valid (out_valid),
        .out_word  (out_word)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    function automatic logic [31:0] model(input logic [63:0] d);
        int          e;
        logic [52:0] sig;
        e = int'(d[62:52]);
        if (e > 896 || d[62:0] == 63'd0) begin
            return {d[63:62], d[58:29]};
        end else if (e >= 874) begin
            sig = {1'b1, d[51:0]};
            e   = e - 1023;
            while (e < -126) begin
                sig = sig >> 1;
                e   = e + 1;
            end
            return {d[63], 8'h00, sig[51:29]};
        end
        return 32'h0;
    endfunction

    function automatic logic [63:0] mk(input logic s, input int e, input logic [51:0] f);
        return {s, 11'(e), f};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input string req, input logic [63:0] d);
        logic [31:0] held;
        @(negedge clk);
        in_valid = 1'b1;
        in_dword = d;
        @(negedge clk);
        in_valid = 1'b0;
        in_dword = ~d;
        check({req, " R2 valid"}, {31'b0, out_valid}, 32'd1);
        check(req, out_word, model(d));
        held = out_word;
        @(negedge clk);
        check("R2 idle valid", {31'b0, out_valid}, 32'd0);
        check("R8 hold", out_word, held);
    endtask

    initial begin
        checks = 0;
        errors = 0;
        done = 1'b0;
        rst_n = 1'b0;
        in_valid = 1'b0;
        in_dword = 64'hFFFF_FFFF_FFFF_FFFF;
        repeat (3) @(negedge clk);
        check("R1 reset valid", {31'b0, out_valid}, 32'd0);
        check("R1 reset word", out_word, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", out_word, 32'd0);

        // directed corners
        apply("R3 exp 897", mk(1'b0, 897, 52'hA_BCDE_F012_3456));
        apply("R5 exp 896", mk(1'b1, 896, 52'hF_FFFF_FFFF_FFFF));
        apply("R5 exp 874", mk(1'b0, 874, 52'h0_0000_0000_0000));
        apply("R6 exp 873", mk(1'b1, 873, 52'hF_FFFF_FFFF_FFFF));
        apply("R4 +0", 64'h0);
        apply("R4 -0", 64'h8000_0000_0000_0000);
        apply("R7 +inf", mk(1'b0, 2047, 52'h0));
        apply("R7 NaN", mk(1'b1, 2047, 52'h8_0000_1234_5678));
        apply("R3 one", 64'h3FF0_0000_0000_0000);
        apply("R6 tiny", mk(1'b0, 1, 52'h1));

        // expected-value spot checks against literal results
        check("R5 literal", model(mk(1'b0, 874, 52'h0)), 32'h0000_0001);
        check("R7 literal", model(mk(1'b0, 2047, 52'h0)), 32'h7F80_0000);

        // constrained random
        void'($urandom(32'd1234));
        for (int i = 0; i < 300; i++) begin
            int          sel;
            int          ex;
            logic [51:0] fr;
            sel = int'($urandom_range(0, 3));
            case (sel)
                0: ex = int'($urandom_range(874, 896));
                1: ex = int'($urandom_range(897, 2047));
                2: ex = int'($urandom_range(0, 873));
                default: ex = int'($urandom_range(870, 900));
            endcase
            fr = {$urandom(), $urandom()};
            apply(ex > 896 ? "R3 rand" : (ex >= 874 ? "R5 rand" : "R6 rand"),
                  mk(1'($urandom()), ex, fr));
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule